// File: doc/BRIEF.md
# DAC Load Strobe Scheduler

This block decides when, inside each sampling interval, the DAC takes its next sample. The internal master clock is supplied as a one-cycle enable (`mclk_en`) on a single fast reference clock. The block counts its ticks from a start-of-interval marker. The nominal load point is one serial-clock period ahead of the position where the ADC raises its output frame sync. A 5-bit advance value can pull that point earlier in steps of eight internal-clock ticks, which shortens the group delay when ADC and DAC run back to back.

The advance value is copied into a shadow register only while the DAC is powered down. A change made while the DAC runs has no effect until the next power-down. The strobe leaves on a serial-clock edge as a single reference-clock pulse. If a large advance would put the load point before the interval starts, the first tick of the interval is used instead.

Top module: `dac_load_sched`

## Requirements
- R1: After synchronous reset `dac_load` is low and the shadow advance is zero. A DAC that is powered through reset and never powered down therefore loads at the zero-advance position.
- R2: With an advance of zero, the load is taken at interval position FS_POS − SCLK_DIV. Positions count `mclk_en` ticks, with position 0 being the tick that carries `intv_start`.
- R3: Each unit of the advance value, taken from `adv_field[4:0]` as an unsigned number 0..31, moves the load position 8 ticks earlier. The load never comes later than position FS_POS − SCLK_DIV.
- R4: When FS_POS − SCLK_DIV − 8·advance is negative, the load is taken at position 0.
- R5: `adv_field` is captured into the shadow register on every clock edge where `dac_pwr` is low. While `dac_pwr` is high the shadow holds, and writes are ignored.
- R6: While `dac_pwr` is high for a whole interval, exactly one load pulse is produced in that interval.
- R7: No load pulse is produced while `dac_pwr` is low.
- R8: `dac_load` is high for exactly one clock. It rises one clock after the qualifying tick, and that tick has `mclk_en` and `sclk_en` both high.
- R9: Positions advance only on `mclk_en` cycles, so the pulse lands at clock P·M + 1 after the start tick when ticks come every M clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_en | input | 1 | Internal master clock tick enable |
| sclk_en | input | 1 | Serial clock edge enable, qualified by `mclk_en` |
| intv_start | input | 1 | Start-of-interval marker, valid on a tick |
| adv_field | input | 5 | Requested advance in 8-tick steps |
| dac_pwr | input | 1 | DAC powered-up flag |
| dac_load | output | 1 | One-clock DAC load strobe |

## Verification
A load decided on the tick at position P goes through a single output register. It therefore appears P·M + 1 clocks after the start tick, where M is the tick spacing the bench chooses for that interval. The bench drives inputs on falling edges and samples `dac_load` on the next falling edge. Each high sample is tagged with its clock index relative to the start tick, and that index must equal the bench-computed value. Shadow capture is visible only through the next powered interval's pulse position. For that reason, every write made while powered is followed by a full interval whose position is compared against the value held from before the write.

// File: rtl/dls_pkg.sv
package dls_pkg;

    localparam int ADV_W    = 5;
    localparam int ADV_STEP = 8;

    typedef enum logic {
        ST_ARMED,
        ST_SPENT
    } fire_st_e;

    // Load position in ticks; negative results clamp to the first tick.
    function automatic int load_pos(input int fs, input int sdiv, input int adv);
        int t;
        t = fs - sdiv - adv * ADV_STEP;
        return (t < 0) ? 0 : t;
    endfunction

endpackage

// File: rtl/dls_shadow.sv
module dls_shadow #(
    parameter int W = dls_pkg::ADV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dac_pwr,
    input  logic [W-1:0] adv_in,
    output logic [W-1:0] adv_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            adv_q <= '0;
        end else if (!dac_pwr) begin
            adv_q <= adv_in;
        end
    end

    p_hold_while_powered_r5: assert property (@(posedge clk) disable iff (rst)
        dac_pwr |=> $stable(adv_q));

endmodule

// File: rtl/dls_pos_cnt.sv
module dls_pos_cnt #(
    parameter int INTV_LEN = 256,
    localparam int POS_W   = $clog2(INTV_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start,
    output logic [POS_W-1:0] cur_pos
);

    localparam logic [POS_W-1:0] POS_MAX = POS_W'(INTV_LEN);

    logic [POS_W-1:0] pos_q;

    assign cur_pos = start ? '0 : pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= POS_MAX;
        end else if (tick && cur_pos != POS_MAX) begin
            pos_q <= cur_pos + 1'b1;
        end
    end

    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (tick && start) |=> (pos_q == POS_W'(1)));

    p_hold_without_tick_r9: assert property (@(posedge clk) disable iff (rst)
        (!tick && !start) |=> $stable(pos_q));

endmodule

// File: rtl/dls_fire.sv
module dls_fire #(
    parameter int POS_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             sclk_en,
    input  logic             start,
    input  logic             dac_pwr,
    input  logic [POS_W-1:0] cur_pos,
    input  logic [POS_W-1:0] target,
    input  logic [POS_W-1:0] latest,
    output logic             load
);
    import dls_pkg::*;

    fire_st_e st_q;
    logic     armed;
    logic     in_window;
    logic     fire;

    assign armed     = start || (st_q == ST_ARMED);
    assign in_window = (cur_pos >= target) && (cur_pos <= latest);
    assign fire      = tick && sclk_en && dac_pwr && armed && in_window;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_SPENT;
            load <= 1'b0;
        end else begin
            load <= fire;
            if (fire) begin
                st_q <= ST_SPENT;
            end else if (tick && start) begin
                st_q <= ST_ARMED;
            end
        end
    end

    p_edge_aligned_r8: assert property (@(posedge clk) disable iff (rst)
        load |-> $past(tick && sclk_en));

    p_single_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        load |=> !load);

endmodule

// File: rtl/dac_load_sched.sv
module dac_load_sched #(
    parameter int INTV_LEN = 256,
    parameter int FS_POS   = 200,
    parameter int SCLK_DIV = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mclk_en,
    input  logic       sclk_en,
    input  logic       intv_start,
    input  logic [4:0] adv_field,
    input  logic       dac_pwr,
    output logic       dac_load
);
    import dls_pkg::*;

    localparam int POS_W = $clog2(INTV_LEN + 1);
    localparam int BASE  = (FS_POS > SCLK_DIV) ? FS_POS - SCLK_DIV : 0;
    localparam logic [POS_W-1:0] LATEST = POS_W'(BASE);

    logic [ADV_W-1:0] adv_q;
    logic [POS_W-1:0] cur_pos;
    logic [POS_W-1:0] target;

    dls_shadow #(.W(ADV_W)) i_shadow (
        .clk     (clk),
        .rst     (rst),
        .dac_pwr (dac_pwr),
        .adv_in  (adv_field),
        .adv_q   (adv_q)
    );

    dls_pos_cnt #(.INTV_LEN(INTV_LEN)) i_pos (
        .clk     (clk),
        .rst     (rst),
        .tick    (mclk_en),
        .start   (intv_start),
        .cur_pos (cur_pos)
    );

    assign target = POS_W'(load_pos(FS_POS, SCLK_DIV, int'(adv_q)));

    dls_fire #(.POS_W(POS_W)) i_fire (
        .clk     (clk),
        .rst     (rst),
        .tick    (mclk_en),
        .sclk_en (sclk_en),
        .start   (intv_start),
        .dac_pwr (dac_pwr),
        .cur_pos (cur_pos),
        .target  (target),
        .latest  (LATEST),
        .load    (dac_load)
    );

    p_needs_power_r7: assert property (@(posedge clk) disable iff (rst)
        dac_load |-> $past(dac_pwr));

    p_not_after_base_r3: assert property (@(posedge clk) disable iff (rst)
        dac_load |-> ($past(cur_pos) <= LATEST));

endmodule

// File: tb/test_dac_load_sched.sv
module test_dac_load_sched;

    localparam int INTV_LEN = 256;
    localparam int FS_POS   = 200;
    localparam int SCLK_DIV = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mclk_en = 1'b0;
    logic       sclk_en = 1'b0;
    logic       intv_start = 1'b0;
    logic [4:0] adv_field = 5'd0;
    logic       dac_pwr = 1'b0;
    logic       dac_load;

    int compared = 0;
    int mismatched = 0;
    int model_adv = 0;
    int wd = 0;

    always #4 clk = ~clk;

    dac_load_sched #(.INTV_LEN(INTV_LEN), .FS_POS(FS_POS), .SCLK_DIV(SCLK_DIV)) i_dac_load_sched (
        .clk        (clk),
        .rst        (rst),
        .mclk_en    (mclk_en),
        .sclk_en    (sclk_en),
        .intv_start (intv_start),
        .adv_field  (adv_field),
        .dac_pwr    (dac_pwr),
        .dac_load   (dac_load)
    );

    function automatic int exp_pos(input int adv);
        int t;
        t = FS_POS - SCLK_DIV - 8 * adv;
        return (t < 0) ? 0 : t;
    endfunction

    task automatic check(input string req, input int act, input int expv);
        compared++;
        if (act != expv) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Set power and field; the model's shadow follows the field while powered down.
    task automatic setup(input logic pwr, input int adv);
        @(negedge clk);
        dac_pwr   = pwr;
        adv_field = 5'(adv);
        if (!pwr) model_adv = adv;
        mclk_en = 1'b0; sclk_en = 1'b0; intv_start = 1'b0;
    endtask

    // One interval with a tick every m clocks; checks pulse count and clock index.
    task automatic run_interval(input int m, input string req);
        int n_hi = 0;
        int at   = -1;
        int expc;
        for (int i = 0; i <= INTV_LEN * m; i++) begin
            @(negedge clk);
            if (i > 0 && dac_load) begin
                n_hi++;
                if (at < 0) at = i;
            end
            if (i < INTV_LEN * m) begin
                mclk_en    = (i % m == 0);
                intv_start = (i == 0);
                sclk_en    = (i % m == 0) && ((i / m) % SCLK_DIV == 0);
            end else begin
                mclk_en = 1'b0; intv_start = 1'b0; sclk_en = 1'b0;
            end
        end
        expc = dac_pwr ? 1 : 0;
        check({req, " pulse count (R6/R7)"}, n_hi, expc);
        if (dac_pwr) check({req, " pulse clock index (R2/R3/R9)"}, at, exp_pos(model_adv) * m + 1);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset with the DAC powered and a nonzero field presented.
        dac_pwr = 1'b1;
        adv_field = 5'd9;
        repeat (4) @(negedge clk);
        check("R1 dac_load during reset", int'(dac_load), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 dac_load after reset", int'(dac_load), 0);
        model_adv = 0;
        run_interval(1, "R1 zero shadow");

        // Directed advances: R2, R3, R4 corners.
        begin
            int advs[7] = '{0, 1, 2, 30, 31, 24, 23};
            foreach (advs[k]) begin
                setup(1'b0, advs[k]);
                run_interval(2, "R7 powered down");
                setup(1'b1, advs[k]);
                run_interval(2, "R3 directed");
            end
        end

        // R5: write while powered is ignored.
        setup(1'b0, 2);
        run_interval(1, "R7 down before R5");
        setup(1'b1, 2);
        setup(1'b1, 17);
        run_interval(1, "R5 write while powered");
        setup(1'b1, 0);
        run_interval(3, "R5 second write ignored");

        // Random mix of power states, fields and tick spacing.
        for (int r = 0; r < 24; r++) begin
            logic pwr;
            int   adv;
            int   m;
            pwr = ($urandom % 4) != 0;
            adv = $urandom % 32;
            m   = 1 + ($urandom % 3);
            setup(pwr, adv);
            run_interval(m, "R6 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule